// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Unit

This block is the arithmetic core of a two-lane multiply-accumulate datapath. It holds two 40-bit accumulators, lane 0 and lane 1. Each lane takes its own pair of 16-bit operands and its own operation code. Both lanes act on the same clock edge. The product is either fully unsigned, with no left shift, or mixed-sign, where the first operand is signed and the second unsigned. The mode is chosen per lane.

Each lane's operation is one of four named actions: HOLD (accumulator unchanged), LOAD (accumulator takes the product), ADD (product added) and SUB (product subtracted). A clear bit zeroes both accumulators. The registered outputs present the low 32-bit word of both accumulators. They also present a half-word taken from lane 1, rounded to nearest on bit 15, with a flag for the case where rounding carries out of the word.

A lane-1 HOLD is the way to read lane 1's rounded half while lane 0 still multiplies. The command word, with the operation codes, mode bits, clear bit and all four operands, arrives on a single input and is qualified by a valid strobe.

Top module: `dual_mac_unit`

## Requirements
- R1: While reset is asserted and after its release, both accumulators, all word and half outputs, the round flag and the output valid are zero.
- R2: With DW=16, the command word has this layout: lane-0 second operand at [15:0], lane-0 first operand at [31:16], lane-1 second operand at [47:32], lane-1 first operand at [63:48], lane-0 op at [65:64], lane-1 op at [67:66], lane-0 mixed bit at [68], lane-1 mixed bit at [69] and clear at [70]. The op codes are 0 HOLD, 1 LOAD, 2 ADD and 3 SUB.
- R3: With its mixed bit 0, a lane multiplies both operands as unsigned and applies no shift. A LOAD therefore shows the word x*y, for example 0x80AD*0x900A gives 0x486656C2.
- R4: With its mixed bit 1, a lane treats the first operand as two's-complement signed and the second as unsigned. The product is sign-extended to 40 bits, for example 0xFEC7*0x5679 gives 0xFF96460F.
- R5: ADD and SUB work modulo 2^40 with no saturation. The word output is the accumulator's low 32 bits.
- R6: HOLD leaves a lane's accumulator and its outputs unchanged while the other lane operates.
- R7: The two lanes use their own operands, op and mode in the same command, with no interaction.
- R8: The half output is A1[31:16] plus A1[15], for example 0xB650D9C4 gives 0xB651 and 0x3593BCCA gives 0x3594.
- R9: When A1[31:15] is all ones, the half output wraps to 0x0000 and the round flag is 1. Otherwise the flag is 0.
- R10: The clear bit zeroes both accumulators whatever the op codes are.
- R11: A command takes effect on the rising edge where in_valid is 1. The outputs and out_valid_o=1 appear after that edge. With in_valid 0, out_valid_o is 0 and all other outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command strobe |
| cmd | input | 71 | Command word (layout in R2) |
| half_o | output | 16 | Rounded upper half of lane 1 |
| a1_word_o | output | 32 | Low word of lane-1 accumulator |
| a0_word_o | output | 32 | Low word of lane-0 accumulator |
| rnd_ovf_o | output | 1 | Rounding carried out of bit 31 |
| out_valid_o | output | 1 | Outputs updated by the last edge |

## Verification
The checker takes for granted that reset is applied once at start. It also takes for granted that the accumulators change only through strobed commands, so each output register always mirrors its accumulator and a HOLD or idle cycle can be checked with $stable against the previous output. The bench drives every command field with defined values away from the clock edge and lowers in_valid between commands. It sweeps a set of corner operands through all op codes and both modes against a 40-bit arithmetic model kept in the bench.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_ADD  = 2'd2,
        ACC_SUB  = 2'd3
    } acc_op_e;

    localparam int NUM_LANES = 2;
endpackage

// File: rtl/dmac_mult.sv
// Product lane: unsigned x unsigned, or signed x unsigned when mixed is set.
module dmac_mult #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          mixed,
    output logic [AW-1:0] prod
);
    localparam int PW = 2 * DW + 2;

    logic signed [DW:0] xs;
    logic signed [DW:0] ys;
    logic signed [PW-1:0] p;

    always_comb begin
        xs = mixed ? $signed({x[DW-1], x}) : $signed({1'b0, x});
        ys = $signed({1'b0, y});
        p  = PW'(xs) * PW'(ys);
        prod = {{(AW - PW){p[PW-1]}}, p};
    end
endmodule

// File: rtl/dmac_lane.sv
// One accumulator with its operation decode.
module dmac_lane
    import dmac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  acc_op_e         op,
    input  logic            mixed,
    input  logic [DW-1:0]   x,
    input  logic [DW-1:0]   y,
    output logic [2*DW-1:0] word_d
);
    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_d;
    logic [AW-1:0] prod;

    dmac_mult #(.DW(DW), .AW(AW)) u_mult (
        .x     (x),
        .y     (y),
        .mixed (mixed),
        .prod  (prod)
    );

    always_comb begin
        unique case (op)
            ACC_HOLD: acc_d = acc_q;
            ACC_LOAD: acc_d = prod;
            ACC_ADD:  acc_d = acc_q + prod;
            ACC_SUB:  acc_d = acc_q - prod;
            default:  acc_d = acc_q;
        endcase
        if (clr) begin
            acc_d = '0;
        end
        word_d = acc_d[2*DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_d;
        end
    end
endmodule

// File: rtl/dmac_round.sv
// Round-to-nearest extraction of the upper half of a word.
module dmac_round #(
    parameter int DW = 16
) (
    input  logic [2*DW-1:0] word,
    output logic [DW-1:0]   half,
    output logic            carry_out
);
    logic [DW:0] sum;

    always_comb begin
        sum       = {1'b0, word[2*DW-1:DW]} + {{DW{1'b0}}, word[DW-1]};
        half      = sum[DW-1:0];
        carry_out = sum[DW];
    end
endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit
    import dmac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40,
    localparam int CW = 4 * DW + 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [CW-1:0]   cmd,
    output logic [DW-1:0]   half_o,
    output logic [2*DW-1:0] a1_word_o,
    output logic [2*DW-1:0] a0_word_o,
    output logic            rnd_ovf_o,
    output logic            out_valid_o
);
    localparam int OP_BASE  = 4 * DW;
    localparam int MIX_BASE = 4 * DW + 4;
    localparam int CLR_BIT  = 4 * DW + 6;

    logic [2*DW-1:0] word_d [NUM_LANES];
    logic [DW-1:0]   half_d;
    logic            ovf_d;
    logic            clr;

    assign clr = cmd[CLR_BIT];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        dmac_lane #(.DW(DW), .AW(AW)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (in_valid),
            .clr    (clr),
            .op     (acc_op_e'(cmd[OP_BASE + 2*g +: 2])),
            .mixed  (cmd[MIX_BASE + g]),
            .x      (cmd[DW*(2*g+1) +: DW]),
            .y      (cmd[DW*(2*g) +: DW]),
            .word_d (word_d[g])
        );
    end

    dmac_round #(.DW(DW)) u_round (
        .word      (word_d[1]),
        .half      (half_d),
        .carry_out (ovf_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
        end else begin
            out_valid_o <= in_valid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_o    <= '0;
            a1_word_o <= '0;
            a0_word_o <= '0;
            rnd_ovf_o <= 1'b0;
        end else if (in_valid) begin
            half_o    <= half_d;
            a1_word_o <= word_d[1];
            a0_word_o <= word_d[0];
            rnd_ovf_o <= ovf_d;
        end
    end
endmodule

// File: rtl/dual_mac_unit_chk.sv
module dual_mac_unit_chk #(
    parameter int DW = 16,
    localparam int CW = 4 * DW + 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [CW-1:0]   cmd,
    input logic [DW-1:0]   half_o,
    input logic [2*DW-1:0] a1_word_o,
    input logic [2*DW-1:0] a0_word_o,
    input logic            rnd_ovf_o,
    input logic            out_valid_o
);
    logic [DW-1:0] x0, y0, x1, y1;
    logic [1:0]    op0, op1;
    logic          mix0, mix1, clr;

    assign y0   = cmd[DW-1:0];
    assign x0   = cmd[2*DW-1:DW];
    assign y1   = cmd[3*DW-1:2*DW];
    assign x1   = cmd[4*DW-1:3*DW];
    assign op0  = cmd[4*DW+1:4*DW];
    assign op1  = cmd[4*DW+3:4*DW+2];
    assign mix0 = cmd[4*DW+4];
    assign mix1 = cmd[4*DW+5];
    assign clr  = cmd[4*DW+6];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid_o); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid_o && $stable(a1_word_o) && $stable(a0_word_o)
                       && $stable(half_o) && $stable(rnd_ovf_o))); // R11

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clr) |=> (a1_word_o == '0 && a0_word_o == '0
                               && half_o == '0 && !rnd_ovf_o)); // R10

    AST_A1_UNSIGNED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && op1 == 2'd1 && !mix1)
        |=> a1_word_o == $past((2*DW)'(x1) * (2*DW)'(y1))); // R3

    AST_A0_UNSIGNED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && op0 == 2'd1 && !mix0)
        |=> a0_word_o == $past((2*DW)'(x0) * (2*DW)'(y0))); // R7

    AST_A1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && op1 == 2'd0)
        |=> ($stable(a1_word_o) && $stable(half_o))); // R6

    AST_ROUND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_ovf_o |-> (half_o == '0 && (&a1_word_o[2*DW-1:DW-1]))); // R9
endmodule

bind dual_mac_unit dual_mac_unit_chk #(.DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .cmd         (cmd),
    .half_o      (half_o),
    .a1_word_o   (a1_word_o),
    .a0_word_o   (a0_word_o),
    .rnd_ovf_o   (rnd_ovf_o),
    .out_valid_o (out_valid_o)
);

// File: tb/dual_mac_unit_test.sv
module dual_mac_unit_test;
    localparam int DW = 16;
    localparam int CW = 4 * DW + 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [CW-1:0] cmd = '0;
    logic [15:0]   half_o;
    logic [31:0]   a1_word_o;
    logic [31:0]   a0_word_o;
    logic          rnd_ovf_o;
    logic          out_valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [39:0] m1 = '0;
    logic [39:0] m0 = '0;

    always #4 clk = ~clk;

    dual_mac_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmd(cmd),
        .half_o(half_o), .a1_word_o(a1_word_o), .a0_word_o(a0_word_o),
        .rnd_ovf_o(rnd_ovf_o), .out_valid_o(out_valid_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [39:0] product(input logic [15:0] x,
                                            input logic [15:0] y,
                                            input logic mix);
        logic [39:0] xe;
        xe = mix ? {{24{x[15]}}, x} : {24'h0, x};
        return xe * {24'h0, y};
    endfunction

    function automatic logic [39:0] apply(input logic [39:0] acc, input logic [1:0] op,
                                          input logic [39:0] p);
        case (op)
            2'd1:    return p;
            2'd2:    return acc + p;
            2'd3:    return acc - p;
            default: return acc;
        endcase
    endfunction

    // Issue one command, update the model, sample after the edge.
    task automatic issue(input logic clr, input logic [1:0] op1, input logic [1:0] op0,
                         input logic mix1, input logic mix0,
                         input logic [15:0] x1, input logic [15:0] y1,
                         input logic [15:0] x0, input logic [15:0] y0);
        @(negedge clk);
        cmd = {clr, mix1, mix0, op1, op0, x1, y1, x0, y0};
        in_valid = 1'b1;
        if (clr) begin
            m1 = '0;
            m0 = '0;
        end else begin
            m1 = apply(m1, op1, product(x1, y1, mix1));
            m0 = apply(m0, op0, product(x0, y0, mix0));
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic compare_all(input string tag);
        logic [16:0] up;
        up = {1'b0, m1[31:16]} + {16'h0, m1[15]};
        check(tag, "a1_word", {8'h0, a1_word_o}, {8'h0, m1[31:0]});
        check(tag, "a0_word", {8'h0, a0_word_o}, {8'h0, m0[31:0]});
        check(tag, "half",    {24'h0, half_o}, {24'h0, up[15:0]});
        check(tag, "rnd_ovf", {39'h0, rnd_ovf_o}, {39'h0, up[16]});
        check(tag, "out_valid", {39'h0, out_valid_o}, 40'h1);
    endtask

    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                              16'hFFFF, 16'h80AD, 16'h900A, 16'hFEC7};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "a1_word", {8'h0, a1_word_o}, 40'h0);
        check("R1", "a0_word", {8'h0, a0_word_o}, 40'h0);
        check("R1", "half", {24'h0, half_o}, 40'h0);
        check("R1", "out_valid", {39'h0, out_valid_o}, 40'h0);
        rst_n = 1'b1;

        // R3, R4, R7, R2: lane 1 unsigned, lane 0 mixed, same command
        issue(1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 16'h80AD, 16'h900A, 16'hFEC7, 16'h5679);
        check("R3", "a1_word", {8'h0, a1_word_o}, 40'h0048_6656_C2);
        check("R4", "a0_word", {8'h0, a0_word_o}, 40'h00FF_9646_0F);
        check("R8", "half", {24'h0, half_o}, 40'h4866);
        compare_all("R7");

        // R11: idle with junk on cmd
        @(negedge clk);
        cmd = {1'b1, 70'h3F_FFFF_FFFF_FFFF_FFFF};
        @(negedge clk);
        check("R11", "out_valid", {39'h0, out_valid_o}, 40'h0);
        check("R11", "a1_word", {8'h0, a1_word_o}, 40'h0048_6656_C2);
        check("R11", "a0_word", {8'h0, a0_word_o}, 40'h00FF_9646_0F);

        // R6: lane 1 holds while lane 0 loads
        issue(1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0003, 16'h0005);
        check("R6", "a1_word", {8'h0, a1_word_o}, 40'h0048_6656_C2);
        check("R6", "a0_word", {8'h0, a0_word_o}, 40'h0F);
        compare_all("R6");

        // R10: clear overrides op codes
        issue(1'b1, 2'd2, 2'd3, 1'b1, 1'b1, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
        check("R10", "a1_word", {8'h0, a1_word_o}, 40'h0);
        check("R10", "a0_word", {8'h0, a0_word_o}, 40'h0);
        compare_all("R10");

        // R5, R9: subtract below zero wraps, rounding carries out
        issue(1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 16'h0001, 16'h0001, 16'h0002, 16'h0001);
        check("R5", "a1_word", {8'h0, a1_word_o}, 40'h00FF_FF_FF_FF);
        check("R9", "half", {24'h0, half_o}, 40'h0);
        check("R9", "rnd_ovf", {39'h0, rnd_ovf_o}, 40'h1);
        compare_all("R5");

        // R8: bit 15 rounds up
        issue(1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 16'h0001, 16'h8000, 16'h0000, 16'h0000);
        check("R8", "half", {24'h0, half_o}, 40'h0001);
        check("R9", "rnd_ovf", {39'h0, rnd_ovf_o}, 40'h0);

        // R5: accumulate past 32 bits into guard bits and back
        for (int k = 0; k < 300; k++) begin
            issue(1'b0, 2'd2, 2'd3, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 16'h8000, 16'hFFFF);
            compare_all("R5");
        end

        // R2/R3/R4/R5/R7/R8 sweep over corner operands, all ops, both modes
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int md = 0; md < 4; md++) begin
                    for (int o = 0; o < 4; o++) begin
                        issue(((i + j + md + o) % 13) == 0,
                              2'(o), 2'(o + i + md),
                              md[0], md[1],
                              vals[i], vals[j], vals[j], vals[(i + md) % 8]);
                        compare_all("R2");
                    end
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule